// File: doc/BRIEF.md
# Gain Ramp and Scale Controller

This block sets the final magnitude of an interpolated complex sample stream. Each accepted sample has its I and Q parts multiplied by the same gain, rounded, and clipped to the output width. In steady operation the gain is the active scale factor alone. A sync event starts a three-phase sequence. The output first fades out, then stays silent for a programmable number of samples, and then fades back in at a newly chosen scale factor. The fade shape comes from a small writable table that supplies one gain step per output sample.

A sync event comes either from a one-cycle pulse on a pin or from a one-cycle command strobe raised by a control-word decoder. During the silent phase a `quiet` output is high. Upstream stages, such as a modulator, may be reconfigured during that window without disturbing the channel. A scale value written at any time waits in a pending register. It takes effect only at the end of the silent phase, so it never appears in the middle of a burst.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: After reset, out_valid, out_i, out_q, quiet and busy are all zero. The active and pending scales both hold unity, which is 0x8000.
- R2: Each sample accepted with in_valid appears on out_i/out_q one clock later, with out_valid high in that cycle. While the block is idle the ramp factor is unity (0x8000), so a unity scale passes the data unchanged.
- R3: A one-cycle high on either sync_pin or cmd_sync while idle starts the sequence, and busy is high from the next clock on.
- R4: The fade-out spends one accepted sample on each table index, running from 63 down to 0. The ramp factor for a sample is the table entry at the current index.
- R5: After index 0 of the fade-out, quiet is high for pause_len accepted samples, where pause_len is captured at the sync and a value of 0 counts as 1. Every sample output during that window is zero.
- R6: A scale write (scale_wr, scale_wdata) only loads the pending register. The active scale changes only when the silent phase ends, so a write with no sync leaves the output gain unchanged.
- R7: The fade-in uses the new active scale and walks the indices upward from 0 to 63, one accepted sample each. The block then returns to idle with a unity ramp factor.
- R8: Each output equals the input times the active scale times the ramp factor, divided by 2^30. Division rounds to nearest, with halves rounded up, and the result saturates to the range -32768..32767. I and Q use the same gain.
- R9: A sync on either input is ignored while busy is high, and the running sequence continues unchanged.
- R10: The ramp index and the pause count move only on cycles with in_valid high. With in_valid low, out_valid is low and out_i/out_q keep their last value.
- R11: Table index 0 always yields zero gain, whatever value is stored at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe at the interpolated rate |
| in_i | input | 16 | In-phase input, two's complement |
| in_q | input | 16 | Quadrature input, two's complement |
| sync_pin | input | 1 | External sync pulse |
| cmd_sync | input | 1 | Sync strobe from the command decoder |
| pause_len | input | 16 | Silent-phase length in samples, captured at sync |
| scale_wr | input | 1 | Pending-scale write strobe |
| scale_wdata | input | 16 | New scale factor, unsigned, 0x8000 is unity |
| ram_wr | input | 1 | Ramp table write strobe |
| ram_waddr | input | 6 | Ramp table write index |
| ram_wdata | input | 16 | Ramp table entry, unsigned, 0x8000 is unity |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Scaled in-phase output |
| out_q | output | 16 | Scaled quadrature output |
| quiet | output | 1 | High during the silent phase |
| busy | output | 1 | High while a sequence is running |

## Verification
An internal fault shows up at the ports on the very next accepted sample. A wrong ramp index or phase gives an output value that differs from the reference gain one clock after that sample. A wrong pause count moves the edges of `quiet` and `busy`, and a scale copied at the wrong moment changes the gain of every later sample. A restart caused by a sync during a sequence puts the index back to the top, so the very next output departs from the expected fade. An index that moves during invalid cycles first shows as a changed gain on the next valid sample.

// File: rtl/grc_pkg.sv
package grc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DOWN  = 2'd1,
        PH_PAUSE = 2'd2,
        PH_UP    = 2'd3
    } grc_phase_e;

endpackage

// File: rtl/grc_ramp_ram.sv
module grc_ramp_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            mem_d[k] = mem_q[k];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= mem_d[k];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/grc_sequencer.sv
module grc_sequencer
    import grc_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_adv,
    input  logic             sync_evt,
    input  logic [CNT_W-1:0] pause_len,
    input  logic             scale_wr,
    input  logic [W-1:0]     scale_wdata,
    input  logic [W-1:0]     ram_rdata,
    output logic [AW-1:0]    ram_raddr,
    output logic [W-1:0]     gain_scale,
    output logic [W-1:0]     gain_ramp,
    output logic             quiet,
    output logic             busy
);

    localparam logic [W-1:0]     UNITY    = {1'b1, {(W-1){1'b0}}};
    localparam logic [AW-1:0]    IDX_LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        grc_phase_e       ph;
        logic [AW-1:0]    idx;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     active;
        logic [W-1:0]     pending;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (scale_wr) begin
            st_d.pending = scale_wdata;
        end
        case (st_q.ph)
            PH_IDLE: begin
                if (sync_evt) begin
                    st_d.ph  = PH_DOWN;
                    st_d.idx = IDX_LAST;
                    st_d.cnt = (pause_len == '0) ? CNT_ONE : pause_len;
                end
            end
            PH_DOWN: begin
                if (sample_adv) begin
                    if (st_q.idx == '0) begin
                        st_d.ph = PH_PAUSE;
                    end else begin
                        st_d.idx = st_q.idx - 1'b1;
                    end
                end
            end
            PH_PAUSE: begin
                if (sample_adv) begin
                    if (st_q.cnt <= CNT_ONE) begin
                        st_d.ph     = PH_UP;
                        st_d.idx    = '0;
                        st_d.active = st_q.pending;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            PH_UP: begin
                if (sample_adv) begin
                    if (st_q.idx == IDX_LAST) begin
                        st_d.ph = PH_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, idx: '0, cnt: '0, active: UNITY, pending: UNITY};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.ph)
            PH_IDLE:  gain_ramp = UNITY;
            PH_PAUSE: gain_ramp = '0;
            default:  gain_ramp = (st_q.idx == '0) ? '0 : ram_rdata;
        endcase
    end

    assign ram_raddr  = st_q.idx;
    assign gain_scale = st_q.active;
    assign quiet      = (st_q.ph == PH_PAUSE);
    assign busy       = (st_q.ph != PH_IDLE);

    AST_SYNC_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sync_evt && !sample_adv) |=> ($stable(st_q.idx) && $stable(st_q.ph))); // R9
    AST_DOWN_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DOWN && sample_adv && st_q.idx != '0) |=> (st_q.ph == PH_DOWN && st_q.idx == $past(st_q.idx) - 1'b1)); // R4
    AST_UP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_UP && sample_adv && st_q.idx != IDX_LAST) |=> (st_q.ph == PH_UP && st_q.idx == $past(st_q.idx) + 1'b1)); // R7
    AST_SCALE_AT_PAUSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active != $past(st_q.active)) |-> ($past(st_q.ph) == PH_PAUSE && st_q.ph == PH_UP)); // R6
    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample_adv) |=> ($stable(st_q.idx) && $stable(st_q.cnt))); // R10

endmodule

// File: rtl/grc_scaler.sv
module grc_scaler #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    input  logic [W-1:0]        gain_scale,
    input  logic [W-1:0]        gain_ramp,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);

    localparam int PW    = 3 * W + 1;
    localparam int SHIFT = 2 * (W - 1);
    localparam logic signed [PW-1:0] RND  = {{(PW-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
    localparam logic signed [PW-1:0] SMAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] SMIN = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

    typedef struct packed {
        logic                valid;
        logic signed [W-1:0] i;
        logic signed [W-1:0] q;
    } out_t;

    out_t o_q, o_d;
    logic [2*W-1:0] gain;

    function automatic logic signed [W-1:0] apply_gain(input logic signed [W-1:0] x,
                                                      input logic [2*W-1:0] g);
        logic signed [PW-1:0] xe;
        logic signed [PW-1:0] ge;
        logic signed [PW-1:0] pr;
        logic signed [PW-1:0] rs;
        xe = {{(PW-W){x[W-1]}}, x};
        ge = {{(PW-2*W){1'b0}}, g};
        pr = xe * ge + RND;
        rs = pr >>> SHIFT;
        if (rs > SMAX) begin
            return SMAX[W-1:0];
        end else if (rs < SMIN) begin
            return SMIN[W-1:0];
        end
        return rs[W-1:0];
    endfunction

    always_comb begin
        gain    = {{W{1'b0}}, gain_scale} * {{W{1'b0}}, gain_ramp};
        o_d     = o_q;
        o_d.valid = in_valid;
        if (in_valid) begin
            o_d.i = apply_gain(in_i, gain);
            o_d.q = apply_gain(in_q, gain);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_i     = o_q.i;
    assign out_q     = o_q.q;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q))); // R10

endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    input  logic                sync_pin,
    input  logic                cmd_sync,
    input  logic [CNT_W-1:0]    pause_len,
    input  logic                scale_wr,
    input  logic [W-1:0]        scale_wdata,
    input  logic                ram_wr,
    input  logic [AW-1:0]       ram_waddr,
    input  logic [W-1:0]        ram_wdata,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q,
    output logic                quiet,
    output logic                busy
);

    localparam logic [W-1:0] UNITY = {1'b1, {(W-1){1'b0}}};

    logic          sync_evt;
    logic [AW-1:0] ram_raddr;
    logic [W-1:0]  ram_rdata;
    logic [W-1:0]  gain_scale;
    logic [W-1:0]  gain_ramp;

    assign sync_evt = sync_pin | cmd_sync;

    grc_ramp_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ram_wr),
        .wr_addr (ram_waddr),
        .wr_data (ram_wdata),
        .rd_addr (ram_raddr),
        .rd_data (ram_rdata)
    );

    grc_sequencer #(.W(W), .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_adv  (in_valid),
        .sync_evt    (sync_evt),
        .pause_len   (pause_len),
        .scale_wr    (scale_wr),
        .scale_wdata (scale_wdata),
        .ram_rdata   (ram_rdata),
        .ram_raddr   (ram_raddr),
        .gain_scale  (gain_scale),
        .gain_ramp   (gain_ramp),
        .quiet       (quiet),
        .busy        (busy)
    );

    grc_scaler #(.W(W)) u_scl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_i       (in_i),
        .in_q       (in_q),
        .gain_scale (gain_scale),
        .gain_ramp  (gain_ramp),
        .out_valid  (out_valid),
        .out_i      (out_i),
        .out_q      (out_q)
    );

    AST_QUIET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && in_valid) |=> (out_i == '0 && out_q == '0)); // R5
    AST_IDLE_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid && gain_scale == UNITY) |=> (out_i == $past(in_i) && out_q == $past(in_q))); // R2
    AST_SYNC_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sync_evt) |=> busy); // R3

endmodule

// File: tb/tb_gain_ramp_ctrl.sv
`timescale 1ns/1ps
module tb_gain_ramp_ctrl;

    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               sync_pin = 1'b0;
    logic               cmd_sync = 1'b0;
    logic [15:0]        pause_len = '0;
    logic               scale_wr = 1'b0;
    logic [15:0]        scale_wdata = '0;
    logic               ram_wr = 1'b0;
    logic [5:0]         ram_waddr = '0;
    logic [15:0]        ram_wdata = '0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;
    logic               quiet;
    logic               busy;

    gain_ramp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .sync_pin(sync_pin), .cmd_sync(cmd_sync), .pause_len(pause_len),
        .scale_wr(scale_wr), .scale_wdata(scale_wdata),
        .ram_wr(ram_wr), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .quiet(quiet), .busy(busy)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string tb_tag = "";

    // behavioural reference: 0 idle, 1 fade-out, 2 silent, 3 fade-in
    int    m_ph = 0, m_idx = 0, m_cnt = 0, m_act = 32768, m_pend = 32768;
    int    m_ram [DEPTH];
    int    m_r;
    bit    m_c1, m_c2;
    logic  m_valid = 1'b0;
    int    m_i = 0, m_q = 0;
    string m_tag = "R1";

    function automatic int ref_gain(int x, int s, int r, output bit clip);
        longint p;
        p = longint'(x) * longint'(s) * longint'(r);
        p = (p + (longint'(1) << 29)) >>> 30;
        clip = 0;
        if (p > 32767) begin p = 32767; clip = 1; end
        if (p < -32768) begin p = -32768; clip = 1; end
        return int'(p);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_cnt = 0; m_act = 32768; m_pend = 32768;
            m_valid = 1'b0; m_i = 0; m_q = 0; m_tag = "R1";
            for (int k = 0; k < DEPTH; k++) m_ram[k] = 0;
        end else begin
            if (m_ph == 0) m_r = 32768;
            else if (m_ph == 2) m_r = 0;
            else m_r = (m_idx == 0) ? 0 : m_ram[m_idx];
            case (m_ph)
                0: m_tag = "R2";
                1: m_tag = "R4";
                2: m_tag = "R5";
                default: m_tag = "R7";
            endcase
            if ((m_ph == 1 || m_ph == 3) && m_idx == 0) m_tag = "R11";
            m_valid = in_valid;
            if (in_valid) begin
                m_i = ref_gain(int'(in_i), m_act, m_r, m_c1);
                m_q = ref_gain(int'(in_q), m_act, m_r, m_c2);
                if (m_c1 || m_c2) m_tag = "R8";
            end else begin
                m_tag = "R10";
            end
            case (m_ph)
                0: if (sync_pin || cmd_sync) begin
                       m_ph = 1; m_idx = DEPTH - 1;
                       m_cnt = (pause_len == 0) ? 1 : int'(pause_len);
                   end
                1: if (in_valid) begin
                       if (m_idx == 0) m_ph = 2; else m_idx--;
                   end
                2: if (in_valid) begin
                       if (m_cnt <= 1) begin m_ph = 3; m_idx = 0; m_act = m_pend; end
                       else m_cnt--;
                   end
                default: if (in_valid) begin
                       if (m_idx == DEPTH - 1) m_ph = 0; else m_idx++;
                   end
            endcase
            if (scale_wr) m_pend = int'(scale_wdata);
            if (ram_wr) m_ram[ram_waddr] = int'(ram_wdata);
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_now();
        string t;
        t = (tb_tag != "") ? tb_tag : m_tag;
        check(out_valid === m_valid, t, int'(out_valid), int'(m_valid));
        check(int'(out_i) == m_i, t, int'(out_i), m_i);
        check(int'(out_q) == m_q, t, int'(out_q), m_q);
        check(quiet === (m_ph == 2), (tb_tag != "") ? tb_tag : "R5", int'(quiet), int'(m_ph == 2));
        check(busy === (m_ph != 0), (tb_tag != "") ? tb_tag : "R3", int'(busy), int'(m_ph != 0));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_now();
        in_valid = 1'b0; sync_pin = 1'b0; cmd_sync = 1'b0; scale_wr = 1'b0; ram_wr = 1'b0;
    endtask

    task automatic rnd_sample(int pct);
        in_valid = (($urandom % 100) < pct);
        in_i = 16'($urandom);
        in_q = 16'($urandom);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    bit saw_quiet = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check(out_valid === 1'b0 && out_i == 0 && out_q == 0, "R1", int'(out_i), 0);
        check(quiet === 1'b0 && busy === 1'b0, "R1", int'({quiet, busy}), 0);

        // R2/R8: idle pass-through with unity gain
        repeat (40) begin rnd_sample(75); step(); end

        // ramp table, address 0 deliberately nonzero (R11)
        for (int k = 0; k < DEPTH; k++) begin
            ram_wr = 1'b1; ram_waddr = 6'(k);
            ram_wdata = (k == 0) ? 16'hFFFF : 16'(k * 1040);
            step();
        end

        // R6: a scale write without sync must not change the gain
        scale_wr = 1'b1; scale_wdata = 16'h2000; step();
        tb_tag = "R6";
        repeat (20) begin rnd_sample(100); step(); end
        tb_tag = "";

        // sequence 1 from the pin, pause of 5 samples, gaps in valid (R10)
        pause_len = 16'd5;
        sync_pin = 1'b1; rnd_sample(100); step();
        check(busy === 1'b1, "R3", int'(busy), 1);
        for (int n = 0; n < 3000 && busy; n++) begin
            rnd_sample(70);
            if (n == 10) begin cmd_sync = 1'b1; tb_tag = "R9"; end
            if (n == 11) sync_pin = 1'b1;
            if (n == 15) tb_tag = "";
            if (n == 20) begin scale_wr = 1'b1; scale_wdata = 16'h6000; end
            if (n == 40) begin scale_wr = 1'b1; scale_wdata = 16'h5000; end
            step();
            if (quiet) saw_quiet = 1;
        end
        check(saw_quiet, "R5", int'(saw_quiet), 1);
        check(busy === 1'b0, "R7", int'(busy), 0);
        repeat (20) begin rnd_sample(80); step(); end

        // sequence 2 from the command strobe, pause 0, saturating gains (R8)
        for (int k = 0; k < DEPTH; k++) begin
            ram_wr = 1'b1; ram_waddr = 6'(k); ram_wdata = 16'hFFFF; step();
        end
        scale_wr = 1'b1; scale_wdata = 16'hFFFF; step();
        pause_len = 16'd0;
        cmd_sync = 1'b1; rnd_sample(100); step();
        check(busy === 1'b1, "R3", int'(busy), 1);
        saw_quiet = 0;
        for (int n = 0; n < 3000 && busy; n++) begin
            in_valid = 1'b1;
            if (n % 3 == 0) begin in_i = 16'sh7FFF; in_q = -16'sh8000; end
            else if (n % 3 == 1) begin in_i = -16'sh8000; in_q = 16'sh7FFF; end
            else begin in_i = 16'($urandom); in_q = 16'($urandom); end
            step();
            if (quiet) saw_quiet = 1;
        end
        check(saw_quiet, "R5", int'(saw_quiet), 1);
        repeat (30) begin rnd_sample(90); step(); end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule